// File: doc/BRIEF.md
# Two-Operator Log-Domain FM Voice

This block produces one sample of a two-operator frequency-modulation voice per sample tick, without a single multiplier. Sine values come out of a quarter-wave table that stores the negative base-2 logarithm of the sine. Attenuation is a plain addition in that log domain. A second table, holding the fractional part of a power of two, turns the log value back into a linear magnitude by a lookup and a right shift. The modulator operator's signed linear output, halved, is added to the carrier operator's phase. The carrier's converted output is the voice sample.

Both operators run through one shared log-sine lookup and one shared log-to-linear converter. A five-state machine steps through them in turn. In `IDLE` the block waits for a tick. The transition `IDLE -> MOD_LOG` (tick accepted) latches the inputs and advances both phase accumulators. `MOD_LOG -> MOD_LIN` stores the modulator's attenuated log value. `MOD_LIN -> CAR_LOG` converts it to linear and folds it into the carrier phase. `CAR_LOG -> CAR_LIN` stores the carrier's attenuated log value. `CAR_LIN -> IDLE` converts it and presents the sample with a one-cycle valid pulse. Ticks that arrive outside `IDLE` are ignored.

Top module: `fm_two_op_voice`

## Requirements
- R1: While reset is asserted and after it is released, `sample_valid` is 0 and `sample_out` is 0 until the first sample completes.
- R2: Each phase accumulator is 10 bits wide and starts at 0. An accepted tick computes its sample from the accumulator values held before that tick. The same tick then adds the frequency word to each accumulator, modulo 1024.
- R3: Log-sine lookup of a 10-bit phase p: the index is p[7:0], mirrored to 255 - p[7:0] when p[8] is 1. Bit p[9] set makes the operator output negative. Entry i holds round(-log2(sin((i + 0.5)·π/512)) × 256).
- R4: Log-to-linear conversion of an attenuated log value L: the fraction is f = L mod 256 and the integer part is k = L div 256. The magnitude is (X[255 - f] + 1024) >> k, where X[j] = round((2^(j/256) - 1) × 1024). The sign from R3 is then applied in two's complement.
- R5: Attenuation is added to the log-sine value before conversion, in units of 1/256 octave. Any sum whose integer part is 11 or more gives a magnitude of exactly 0.
- R6: The carrier phase used for the sample is (carrier accumulator + (signed modulator output >>> 1)) mod 1024. The modulator output is the R3/R4/R5 result for the modulator phase and modulator attenuation.
- R7: `sample_valid` is high for exactly one cycle, starting 4 clock edges after the edge that accepts the tick. `sample_out` changes only when `sample_valid` is high and otherwise holds its value.
- R8: A tick that arrives while a sample is in progress is ignored and does not advance the accumulators.
- R9: Frequency words and attenuations are captured at the accepting edge. Changes to them during processing do not affect that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample request, accepted in IDLE |
| mod_freq | input | 10 | Modulator phase increment per sample |
| car_freq | input | 10 | Carrier phase increment per sample |
| mod_att | input | 12 | Modulator attenuation, 1/256 octave units |
| car_att | input | 12 | Carrier attenuation, 1/256 octave units |
| sample_out | output | 12 | Signed voice sample |
| sample_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
A sample is due on the fourth rising edge after the edge that accepts its tick. It is visible from the falling edge that follows. Both the reference model and the directed tasks count cycles from the accepting edge, so every comparison happens at a falling edge once that edge's outputs have settled. The model mirrors only the tick-acceptance rule: a counter of four pending edges blocks new ticks. It compares `sample_valid` and `sample_out` on every clock. A directed check measures that latency as exactly five falling edges after the one that raised the tick.

// File: rtl/fm_voice_pkg.sv
package fm_voice_pkg;

    localparam int TBL_AW = 8;
    localparam int TBL_N  = 1 << TBL_AW;
    localparam int PH_W   = TBL_AW + 2;
    localparam int LOG_W  = 12;
    localparam int EXP_W  = 10;
    localparam int MANT_W = EXP_W + 1;
    localparam int LIN_W  = MANT_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MOD_LOG,
        ST_MOD_LIN,
        ST_CAR_LOG,
        ST_CAR_LIN
    } voice_state_t;

    // -log2 of a quarter-wave sine sample, scaled by the table size
    function automatic logic [LOG_W-1:0] logsin_entry(input int idx);
        real s;
        real v;
        s = $sin((real'(idx) + 0.5) * 3.14159265358979 / real'(2 * TBL_N));
        v = -($ln(s) / $ln(2.0)) * real'(TBL_N);
        return LOG_W'($rtoi(v + 0.5));
    endfunction

    // fractional power of two minus one, scaled to the mantissa
    function automatic logic [EXP_W-1:0] exp_entry(input int idx);
        real v;
        v = ($pow(2.0, real'(idx) / real'(TBL_N)) - 1.0) * real'(1 << EXP_W);
        return EXP_W'($rtoi(v + 0.5));
    endfunction

endpackage

// File: rtl/fm_logsin_lookup.sv
module fm_logsin_lookup
    import fm_voice_pkg::*;
(
    input  logic [PH_W-1:0]  phase,
    output logic [LOG_W-1:0] log_val,
    output logic             neg
);

    logic [TBL_N*LOG_W-1:0] rom_flat;
    logic [TBL_AW-1:0]      idx;

    for (genvar g = 0; g < TBL_N; g++) begin : g_rom
        localparam logic [LOG_W-1:0] ENTRY = logsin_entry(g);
        assign rom_flat[g*LOG_W +: LOG_W] = ENTRY;
    end

    always_comb begin
        idx     = phase[PH_W-2] ? ~phase[TBL_AW-1:0] : phase[TBL_AW-1:0];
        neg     = phase[PH_W-1];
        log_val = rom_flat[idx*LOG_W +: LOG_W];
    end

endmodule

// File: rtl/fm_log2lin.sv
module fm_log2lin
    import fm_voice_pkg::*;
#(
    parameter int SUM_W = 13
) (
    input  logic [SUM_W-1:0]        att_sum,
    input  logic                    neg,
    output logic signed [LIN_W-1:0] lin
);

    localparam int INT_W = SUM_W - TBL_AW;

    logic [TBL_N*EXP_W-1:0] rom_flat;
    logic [TBL_AW-1:0]      frac_inv;
    logic [INT_W-1:0]       int_part;
    logic [MANT_W-1:0]      mant;
    logic [MANT_W-1:0]      mag;

    for (genvar g = 0; g < TBL_N; g++) begin : g_rom
        localparam logic [EXP_W-1:0] ENTRY = exp_entry(g);
        assign rom_flat[g*EXP_W +: EXP_W] = ENTRY;
    end

    always_comb begin
        frac_inv = ~att_sum[TBL_AW-1:0];
        int_part = att_sum[SUM_W-1:TBL_AW];
        mant     = {1'b1, rom_flat[frac_inv*EXP_W +: EXP_W]};
        if (32'(int_part) >= MANT_W) begin
            mag = '0;
        end else begin
            mag = mant >> int_part;
        end
        lin = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

endmodule

// File: rtl/fm_two_op_voice.sv
module fm_two_op_voice
    import fm_voice_pkg::*;
#(
    parameter int ATT_W     = 12,
    parameter int MOD_SHIFT = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic [PH_W-1:0]         mod_freq,
    input  logic [PH_W-1:0]         car_freq,
    input  logic [ATT_W-1:0]        mod_att,
    input  logic [ATT_W-1:0]        car_att,
    output logic signed [LIN_W-1:0] sample_out,
    output logic                    sample_valid
);

    localparam int SUM_W = ((LOG_W > ATT_W) ? LOG_W : ATT_W) + 1;

    voice_state_t state_q, state_d;

    logic [PH_W-1:0]         acc_mod_q, acc_car_q;
    logic [PH_W-1:0]         ph_mod_q, ph_car_q;
    logic [ATT_W-1:0]        att_mod_q, att_car_q;
    logic [SUM_W-1:0]        log_sum_q;
    logic                    neg_q;
    logic signed [LIN_W-1:0] sample_q;
    logic                    valid_q;

    logic [PH_W-1:0]         sel_phase;
    logic [ATT_W-1:0]        sel_att;
    logic [LOG_W-1:0]        rom_log;
    logic                    rom_neg;
    logic [SUM_W-1:0]        att_sum;
    logic signed [LIN_W-1:0] lin;
    logic signed [LIN_W-1:0] mod_off;

    // shared operator datapath
    always_comb begin
        sel_phase = (state_q == ST_MOD_LOG) ? ph_mod_q  : ph_car_q;
        sel_att   = (state_q == ST_MOD_LOG) ? att_mod_q : att_car_q;
        att_sum   = SUM_W'(rom_log) + SUM_W'(sel_att);
        mod_off   = lin >>> MOD_SHIFT;
    end

    fm_logsin_lookup u_logsin (
        .phase   (sel_phase),
        .log_val (rom_log),
        .neg     (rom_neg)
    );

    fm_log2lin #(.SUM_W(SUM_W)) u_log2lin (
        .att_sum (log_sum_q),
        .neg     (neg_q),
        .lin     (lin)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (tick) state_d = ST_MOD_LOG;
            ST_MOD_LOG: state_d = ST_MOD_LIN;
            ST_MOD_LIN: state_d = ST_CAR_LOG;
            ST_CAR_LOG: state_d = ST_CAR_LIN;
            ST_CAR_LIN: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_mod_q <= '0;
            acc_car_q <= '0;
            ph_mod_q  <= '0;
            ph_car_q  <= '0;
            att_mod_q <= '0;
            att_car_q <= '0;
            log_sum_q <= '0;
            neg_q     <= 1'b0;
            sample_q  <= '0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (tick) begin
                        ph_mod_q  <= acc_mod_q;
                        ph_car_q  <= acc_car_q;
                        att_mod_q <= mod_att;
                        att_car_q <= car_att;
                        acc_mod_q <= acc_mod_q + mod_freq;
                        acc_car_q <= acc_car_q + car_freq;
                    end
                end
                ST_MOD_LOG, ST_CAR_LOG: begin
                    log_sum_q <= att_sum;
                    neg_q     <= rom_neg;
                end
                ST_MOD_LIN: begin
                    ph_car_q <= ph_car_q + mod_off[PH_W-1:0];
                end
                ST_CAR_LIN: begin
                    sample_q <= lin;
                    valid_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign sample_out   = sample_q;
    assign sample_valid = valid_q;

endmodule

// File: rtl/fm_voice_checker.sv
module fm_voice_checker
    import fm_voice_pkg::*;
#(
    parameter int SUM_W = 13
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick,
    input voice_state_t            state_q,
    input logic [PH_W-1:0]         acc_mod_q,
    input logic [PH_W-1:0]         acc_car_q,
    input logic [SUM_W-1:0]        log_sum_q,
    input logic signed [LIN_W-1:0] sample_out,
    input logic                    sample_valid
);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    a_r7_valid_after_last_stage: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> $past(state_q) == ST_CAR_LIN);

    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable(sample_out));

    a_r8_acc_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(acc_mod_q) && $stable(acc_car_q)));

    a_r2_acc_frozen_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !tick) |=> ($stable(acc_mod_q) && $stable(acc_car_q)));

    a_r5_saturate_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAR_LIN && 32'(log_sum_q[SUM_W-1:TBL_AW]) >= MANT_W) |=> sample_out == 0);

    a_r2_stage_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MOD_LOG) |=> (state_q == ST_MOD_LIN));

endmodule

bind fm_two_op_voice fm_voice_checker #(.SUM_W(SUM_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .state_q      (state_q),
    .acc_mod_q    (acc_mod_q),
    .acc_car_q    (acc_car_q),
    .log_sum_q    (log_sum_q),
    .sample_out   (sample_out),
    .sample_valid (sample_valid)
);

// File: tb/fm_two_op_voice_test.sv
`timescale 1ns/1ps
module fm_two_op_voice_test;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [9:0]        mod_freq = '0;
    logic [9:0]        car_freq = '0;
    logic [11:0]       mod_att = '0;
    logic [11:0]       car_att = '0;
    logic signed [11:0] sample_out;
    logic              sample_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fm_two_op_voice uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .mod_freq     (mod_freq),
        .car_freq     (car_freq),
        .mod_att      (mod_att),
        .car_att      (car_att),
        .sample_out   (sample_out),
        .sample_valid (sample_valid)
    );

    // tables from the requirement formulas
    int logt [256];
    int expt [256];

    initial begin
        for (int i = 0; i < 256; i++) begin
            real s;
            s = $sin((real'(i) + 0.5) * 3.14159265358979 / 512.0);
            logt[i] = $rtoi(-($ln(s) / $ln(2.0)) * 256.0 + 0.5);
            expt[i] = $rtoi(($pow(2.0, real'(i) / 256.0) - 1.0) * 1024.0 + 0.5);
        end
    end

    function automatic int lin_of(int lv, bit ng);
        int k, f, m;
        k = lv >> 8;
        f = lv & 255;
        if (k >= 11) m = 0;
        else m = (expt[255 - f] + 1024) >> k;
        return ng ? -m : m;
    endfunction

    function automatic int lsin(int ph, output bit ng);
        int idx;
        ng  = ph[9];
        idx = ph & 255;
        if (ph[8]) idx = 255 - idx;
        return logt[idx];
    endfunction

    function automatic int voice(int pm, int pc, int am, int ac);
        int mv, cph, lv;
        bit n;
        lv  = lsin(pm, n);
        mv  = lin_of(lv + am, n);
        cph = (pc + (mv >>> 1)) & 1023;
        lv  = lsin(cph, n);
        return lin_of(lv + ac, n);
    endfunction

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    // behavioural reference model
    int m_pend = 0;
    int m_accm = 0;
    int m_accc = 0;
    int m_next = 0;
    bit m_valid = 0;
    int m_sample = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_accm = 0; m_accc = 0; m_valid = 0; m_sample = 0;
        end else begin
            m_valid = 0;
            if (m_pend > 0) begin
                m_pend--;
                if (m_pend == 0) begin
                    m_valid  = 1;
                    m_sample = m_next;
                end
            end else if (tick) begin
                m_next = voice(m_accm, m_accc, int'(mod_att), int'(car_att));
                m_accm = (m_accm + int'(mod_freq)) & 1023;
                m_accc = (m_accc + int'(car_freq)) & 1023;
                m_pend = 4;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7 R8 valid timing", int'(sample_valid), int'(m_valid));
            check("R2 R4 R6 R9 sample", int'(sample_out), m_sample);
        end
    end

    // one tick held for 'len' falling edges; returns sample and latency
    task automatic do_tick(int len, output int smp, output int lat);
        @(negedge clk);
        tick = 1'b1;
        lat = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            lat++;
            if (i == len - 1) tick = 1'b0;
        end
        while (!sample_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        smp = int'(sample_out);
    endtask

    int s, lat, v0;

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(sample_valid), 0);
        check("R1 sample in reset", int'(sample_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", int'(sample_valid), 0);
        check("R1 sample after reset", int'(sample_out), 0);

        v0 = lin_of(logt[0], 0);
        mod_freq = 0; car_freq = 256; mod_att = 12'hFFF; car_att = 0;

        do_tick(1, s, lat);
        check("R7 latency", lat, 5);
        check("R3 phase 0", s, v0);

        // held tick covers busy edges; attenuation changed mid-sample
        @(negedge clk);
        tick = 1'b1;
        repeat (2) @(negedge clk);
        car_att = 12'hFFF;
        mod_freq = 10'd300;
        repeat (2) @(negedge clk);
        tick = 1'b0;
        while (!sample_valid) @(negedge clk);
        check("R3 R9 quarter peak", int'(sample_out), 2042);
        car_att = 0; mod_freq = 0;

        do_tick(1, s, lat);
        check("R3 R8 phase 512 negative", s, -v0);
        do_tick(1, s, lat);
        check("R3 mirrored negative peak", s, -2042);

        car_att = 2816;
        do_tick(1, s, lat);
        check("R5 saturate at phase 0", s, 0);

        car_freq = 0; car_att = 256;
        do_tick(1, s, lat);
        check("R4 R5 one octave down", s, 1021);
        car_att = 2815;
        do_tick(1, s, lat);
        check("R4 R5 last nonzero step", s, 1);
        car_att = 2816;
        do_tick(1, s, lat);
        check("R5 boundary zero", s, 0);

        // modulation active: modulator phase 0 at full level
        mod_att = 0; car_att = 0;
        do_tick(1, s, lat);
        check("R6 modulated carrier", s, voice(0, 256, 0, 0));

        // varied stimulus, inputs changing every cycle
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            tick     = ($urandom_range(0, 2) != 0);
            mod_freq = 10'($urandom_range(0, 1023));
            car_freq = 10'($urandom_range(0, 1023));
            mod_att  = 12'($urandom_range(0, 1500));
            car_att  = 12'($urandom_range(0, 3200));
        end
        @(negedge clk);
        tick = 1'b0;
        repeat (8) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule